// File: doc/BRIEF.md
# UART Modem Handshake Control and Status with Internal Loopback

This block holds the modem-side handshake state of a 16550-style serial port. A control register, written by the host, drives the four handshake outputs (data-terminal-ready, request-to-send and two general-purpose outputs). A status register presents the current levels of the four handshake inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) together with four sticky change flags. An interrupt request is raised while any change flag is set. Reading the status register clears the change flags.

Control bit 4 selects a self-test loopback. In this mode the transmit serial stream is sent straight back to the receiver path, and the external serial input is ignored. The four control bits drive the status inputs in place of the external handshake pins. The external serial output idles at mark and the handshake output pins go inactive, so the far end sees an idle, disconnected port.

The handshake inputs are asynchronous. They pass through a two-stage synchronizer before the block detects any change. A change that arrives in the same cycle as a status read is kept, not dropped. All pin levels on the ports are "asserted = 1". Any inversion at the pad belongs outside this block.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset, the control register is 0, all four handshake outputs are 0, the status register reads 0x00 while all handshake inputs are 0, and `msi_req` is 0.
- R2: A write (`ctl_wr_en` high for one cycle) stores `ctl_wr_data[4:0]`. When bit 4 is 0, bit 0 drives `dtr_out`, bit 1 `rts_out`, bit 2 `out1_out` and bit 3 `out2_out`, from the first clock edge after the write. Bits 7:5 have no effect.
- R3: With control bit 4 set (loopback), `sout` is 1, all four handshake outputs are 0, `rx_serial` equals `tx_serial`, and `sin` is ignored.
- R4: Status bits 4..7 show clear-to-send, data-set-ready, ring and carrier-detect. In normal mode these are the pin levels, valid two clock edges after a pin change. In loopback they are control bits 1, 0, 2 and 3 respectively, and the external handshake pins are ignored.
- R5: Status bit 0 (clear-to-send), bit 1 (data-set-ready) and bit 3 (carrier-detect) set on any change of their line. They appear on the same edge as the new level in bits 4..7.
- R6: Status bit 2 sets only when the ring line goes from 1 to 0. A 0-to-1 ring transition leaves it unchanged.
- R7: Status bits 0..3 stay set until a read (`sts_rd` high for one cycle), which clears them at the end of that cycle. A change detected on that same edge is kept set.
- R8: `msi_req` is 1 exactly when any of status bits 0..3 is 1.
- R9: With control bit 4 clear, `sout` equals `tx_serial` and `rx_serial` equals `sin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 8 | Control register write data |
| sts_rd | input | 1 | Status register read strobe, clears change flags |
| cts_in | input | 1 | Clear-to-send pin, asynchronous |
| dsr_in | input | 1 | Data-set-ready pin, asynchronous |
| ri_in | input | 1 | Ring indicator pin, asynchronous |
| dcd_in | input | 1 | Carrier detect pin, asynchronous |
| sin | input | 1 | External serial input line |
| tx_serial | input | 1 | Serial stream from the transmitter shifter |
| dtr_out | output | 1 | Data-terminal-ready pin |
| rts_out | output | 1 | Request-to-send pin |
| out1_out | output | 1 | General-purpose output 1 |
| out2_out | output | 1 | General-purpose output 2 |
| sout | output | 1 | External serial output line |
| rx_serial | output | 1 | Serial stream to the receiver shifter |
| status_q | output | 8 | Status register value |
| msi_req | output | 1 | Modem-status-change interrupt request |

## Verification
Control pins, `sout` and `rx_serial` settle one edge after a control write. Serial routing is combinational and is checked in the same cycle the serial inputs are driven. Status levels and change flags are due two edges after a pin change, and three edges after a control write when loopback feeds the status inputs. The bench drives on falling edges and samples only after counting exactly those rising edges. Change-flag clearing is checked one edge after the read strobe. The coincident case places the second synchronizer edge inside the read cycle.

// File: rtl/uart_mdm_pkg.sv
// Shared constants for the modem handshake block.
// Assumes: the control register holds five meaningful bits and four lines are monitored.
package uart_mdm_pkg;
    localparam int CTL_W    = 5;
    localparam int LINE_N   = 4;
    localparam int SYNC_N   = 2;
    // control register bit positions
    localparam int CB_DTR   = 0;
    localparam int CB_RTS   = 1;
    localparam int CB_OUT1  = 2;
    localparam int CB_OUT2  = 3;
    localparam int CB_LOOP  = 4;
    // handshake line positions inside a line vector (and status bits [3:0]/[7:4])
    localparam int LN_CTS   = 0;
    localparam int LN_DSR   = 1;
    localparam int LN_RI    = 2;
    localparam int LN_DCD   = 3;
endpackage

// File: rtl/mdm_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous bits.
// Exposes the final stage and the stage before it so that a consumer can see
// the value that the final stage will load on the next edge.
// Assumes: STAGES >= 2; bits are independent (no bus coherency needed).
module mdm_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_next
);
    logic [STAGES-1:0][W-1:0] chain;

    // shift the asynchronous sample through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q      = chain[STAGES-1];
    assign q_next = chain[STAGES-2];
endmodule

// File: rtl/mdm_ctl.sv
// Control register and serial / handshake pin routing.
// In loopback the external serial output idles at mark, handshake pins go
// inactive and the transmit stream is returned to the receiver path.
// Assumes: the write strobe is synchronous to clk.
module mdm_ctl
    import uart_mdm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             sin,
    input  logic             tx_serial,
    output logic [CTL_W-1:0] ctl_q,
    output logic             dtr_out,
    output logic             rts_out,
    output logic             out1_out,
    output logic             out2_out,
    output logic             sout,
    output logic             rx_serial
);
    logic loop_on;

    // hold the control bits written by the host
    always_ff @(posedge clk) begin
        if (!rst_n)     ctl_q <= '0;
        else if (wr_en) ctl_q <= wr_data;
    end

    assign loop_on = ctl_q[CB_LOOP];

    // gate handshake pins and steer the serial streams by mode
    always_comb begin
        dtr_out   = ctl_q[CB_DTR]  & ~loop_on;
        rts_out   = ctl_q[CB_RTS]  & ~loop_on;
        out1_out  = ctl_q[CB_OUT1] & ~loop_on;
        out2_out  = ctl_q[CB_OUT2] & ~loop_on;
        sout      = loop_on ? 1'b1 : tx_serial;
        rx_serial = loop_on ? tx_serial : sin;
    end

    // R2: a write is reflected in the register on the next edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctl_q == $past(wr_data)));

    // R3: in loopback the receiver sees the transmitter and the line idles
    p_loop_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> (rx_serial == tx_serial && sout == 1'b1));

    // R3: no handshake pin is asserted during loopback
    p_loop_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        loop_on |-> !(dtr_out | rts_out | out1_out | out2_out));
endmodule

// File: rtl/mdm_status.sv
// Status register: current line levels plus sticky change flags.
// Change flags for CTS/DSR/DCD set on either edge, ring on its falling edge.
// A read clears the flags; a change detected on the same edge survives.
// Assumes: cur/nxt come from the last two synchronizer stages.
module mdm_status
    import uart_mdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_N-1:0] cur,
    input  logic [LINE_N-1:0] nxt,
    input  logic              rd,
    output logic [7:0]        status_q,
    output logic              irq
);
    logic [LINE_N-1:0] chg;
    logic [LINE_N-1:0] delta_q;

    // classify the transition that the final stage takes on this edge
    always_comb begin
        chg         = cur ^ nxt;
        chg[LN_RI]  = cur[LN_RI] & ~nxt[LN_RI];
    end

    // accumulate change flags, clearing on read but keeping new events
    always_ff @(posedge clk) begin
        if (!rst_n)  delta_q <= '0;
        else if (rd) delta_q <= chg;
        else         delta_q <= delta_q | chg;
    end

    assign status_q = {cur, delta_q};
    assign irq      = |delta_q;

    // R5: a clear-to-send level change is flagged on the same edge
    p_cts_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur[LN_CTS] != $past(cur[LN_CTS])) |-> delta_q[LN_CTS]);

    // R6: a falling ring line is flagged on the same edge
    p_ri_trail_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cur[LN_RI]) |-> delta_q[LN_RI]);

    // R7: flags never drop without a read
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    // R7: a read with nothing new in flight leaves all flags clear
    p_read_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && nxt == cur) |=> (delta_q == '0));
endmodule

// File: rtl/uart_modem_ctl.sv
// Top of the modem handshake block: control register, pin routing,
// input synchronizer with loopback source select, and status register.
// Assumes: handshake pins are asynchronous, asserted = 1.
module uart_modem_ctl
    import uart_mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr_en,
    input  logic [7:0] ctl_wr_data,
    input  logic       sts_rd,
    input  logic       cts_in,
    input  logic       dsr_in,
    input  logic       ri_in,
    input  logic       dcd_in,
    input  logic       sin,
    input  logic       tx_serial,
    output logic       dtr_out,
    output logic       rts_out,
    output logic       out1_out,
    output logic       out2_out,
    output logic       sout,
    output logic       rx_serial,
    output logic [7:0] status_q,
    output logic       msi_req
);
    logic [CTL_W-1:0]  ctl_q;
    logic [LINE_N-1:0] line_src;
    logic [LINE_N-1:0] line_cur;
    logic [LINE_N-1:0] line_nxt;
    logic              unused_wdata;

    assign unused_wdata = &{1'b0, ctl_wr_data[7:CTL_W]};

    mdm_ctl u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctl_wr_en),
        .wr_data   (ctl_wr_data[CTL_W-1:0]),
        .sin       (sin),
        .tx_serial (tx_serial),
        .ctl_q     (ctl_q),
        .dtr_out   (dtr_out),
        .rts_out   (rts_out),
        .out1_out  (out1_out),
        .out2_out  (out2_out),
        .sout      (sout),
        .rx_serial (rx_serial)
    );

    // pick the status line source: external pins or looped control bits
    always_comb begin
        if (ctl_q[CB_LOOP]) begin
            line_src[LN_CTS] = ctl_q[CB_RTS];
            line_src[LN_DSR] = ctl_q[CB_DTR];
            line_src[LN_RI]  = ctl_q[CB_OUT1];
            line_src[LN_DCD] = ctl_q[CB_OUT2];
        end else begin
            line_src[LN_CTS] = cts_in;
            line_src[LN_DSR] = dsr_in;
            line_src[LN_RI]  = ri_in;
            line_src[LN_DCD] = dcd_in;
        end
    end

    mdm_sync #(.W(LINE_N), .STAGES(SYNC_N)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d      (line_src),
        .q      (line_cur),
        .q_next (line_nxt)
    );

    mdm_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur      (line_cur),
        .nxt      (line_nxt),
        .rd       (sts_rd),
        .status_q (status_q),
        .irq      (msi_req)
    );

    // R8: interrupt request tracks the change flags
    p_irq_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        msi_req == (|status_q[3:0]));

    // R9: normal mode routes serial streams straight through
    p_pass_thru_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[CB_LOOP] |-> (sout == tx_serial && rx_serial == sin));
endmodule

// File: tb/tb_uart_modem_ctl.sv
module tb_uart_modem_ctl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       ctl_wr_en;
    logic [7:0] ctl_wr_data;
    logic       sts_rd;
    logic       cts_in, dsr_in, ri_in, dcd_in;
    logic       sin, tx_serial;
    logic       dtr_out, rts_out, out1_out, out2_out;
    logic       sout, rx_serial;
    logic [7:0] status_q;
    logic       msi_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    uart_modem_ctl dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .sts_rd(sts_rd), .cts_in(cts_in), .dsr_in(dsr_in), .ri_in(ri_in), .dcd_in(dcd_in),
        .sin(sin), .tx_serial(tx_serial), .dtr_out(dtr_out), .rts_out(rts_out),
        .out1_out(out1_out), .out2_out(out2_out), .sout(sout), .rx_serial(rx_serial),
        .status_q(status_q), .msi_req(msi_req)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // pins vector order: [0]=cts [1]=dsr [2]=ri [3]=dcd
    task automatic set_pins(input logic [3:0] v);
        {dcd_in, ri_in, dsr_in, cts_in} = v;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr_en = 1'b1; ctl_wr_data = v;
        step(1);
        ctl_wr_en = 1'b0;
    endtask

    task automatic rd_sts();
        sts_rd = 1'b1;
        step(1);
        sts_rd = 1'b0;
    endtask

    function automatic logic [3:0] exp_delta(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] d;
        d    = a ^ b;
        d[2] = a[2] & ~b[2];
        return d;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] pins_ext;
        rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = '0; sts_rd = 1'b0;
        sin = 1'b0; tx_serial = 1'b0;
        set_pins(4'h0);
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 pins", {4'h0, dtr_out, rts_out, out1_out, out2_out}, 8'h00);
        check("R1 status", status_q, 8'h00);
        check("R1 irq", {7'h0, msi_req}, 8'h00);

        // R2/R3/R4/R9: sweep every control write value
        pins_ext = 4'b1010;
        set_pins(pins_ext);
        step(3);
        rd_sts();
        for (int v = 0; v < 256; v++) begin
            logic lb;
            logic [7:0] wv;
            wv = v[7:0];
            lb = wv[4];
            wr_ctl(wv);
            check("R2 R3 dtr/rts/out1/out2",
                  {4'h0, dtr_out, rts_out, out1_out, out2_out},
                  lb ? 8'h00 : {4'h0, wv[0], wv[1], wv[2], wv[3]});
            for (int s = 0; s < 4; s++) begin
                tx_serial = s[0]; sin = s[1];
                #0.5;
                check(lb ? "R3 sout" : "R9 sout", {7'h0, sout}, lb ? 8'h01 : {7'h0, s[0]});
                check(lb ? "R3 rx_serial" : "R9 rx_serial", {7'h0, rx_serial},
                      lb ? {7'h0, s[0]} : {7'h0, s[1]});
            end
            step(2);
            check("R4 status levels", {4'h0, status_q[7:4]},
                  lb ? {4'h0, wv[3], wv[2], wv[0], wv[1]} : {4'h0, pins_ext});
            rd_sts();
            step(1);
        end
        wr_ctl(8'h00);
        step(3);
        rd_sts();

        // R5/R6/R7/R8: every pin transition pair
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic [3:0] ed;
                set_pins(a[3:0]);
                step(3);
                rd_sts();
                check("R7 cleared after read", {4'h0, status_q[3:0]}, 8'h00);
                set_pins(b[3:0]);
                step(1);
                check("R5 not before two edges", {4'h0, status_q[3:0]}, 8'h00);
                step(1);
                ed = exp_delta(a[3:0], b[3:0]);
                check("R5 R6 change flags", status_q, {b[3:0], ed});
                check("R8 irq", {7'h0, msi_req}, {7'h0, |ed});
                step(2);
                check("R7 sticky", {4'h0, status_q[3:0]}, {4'h0, ed});
            end
        end

        // R7: change coinciding with a read survives, older flag is cleared
        set_pins(4'h0); step(3); rd_sts();
        set_pins(4'b1000); step(3);
        check("R5 dcd flag set", {4'h0, status_q[3:0]}, 8'h08);
        cts_in = 1'b1;
        step(1);
        rd_sts();
        check("R7 coincident change kept", {4'h0, status_q[3:0]}, 8'h01);
        check("R4 level after coincident", {4'h0, status_q[7:4]}, 8'h09);
        step(1);
        rd_sts();
        check("R8 irq off after final read", {7'h0, msi_req}, 8'h00);

        // R4: external pins ignored in loopback
        wr_ctl(8'h10);
        step(3);
        rd_sts();
        set_pins(4'b0101);
        step(3);
        check("R4 pins ignored in loopback", status_q, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule